// File: doc/BRIEF.md
# Cable Compensation Level Latch

This block chooses one of four cable-drop compensation weightings a single time after the supply comes up, and then keeps that choice. An external resistor on a programming pin sets a current. A converter outside the block digitizes that current and delivers it as an unsigned code with a valid strobe. A lower resistance gives a larger current, and a larger current selects a heavier weighting. When the supply-good indication rises, a capture window opens. The first valid measurement inside that window is sorted against three programmable bin boundaries. The block then locks a 2-bit level code, a compensation value in millivolts for the voltage-regulation reference, and a scaled offset for the output over-voltage trip point.

If the window closes with no measurement, the block takes the lightest weighting and sets a sticky timeout flag. A not-ready output stays high until a level is locked, so that switching logic downstream can wait. A synchronous clear, raised on undervoltage or on a protection shutdown, puts the block back in the unlocked state. Only the next rising edge of supply-good starts a new capture.

Top module: `cable_comp_latch`

## Requirements
- R1: After reset, not_ready is 1, lvl_code is 0, comp_mv is 0, ovp_ofs is 0 and tmo_flag is 0.
- R2: A captured code is classified by counting the boundaries it reaches. A code below bnd_lo gives level 0, a code from bnd_lo to below bnd_mid gives 1, a code from bnd_mid to below bnd_hi gives 2, and a code at or above bnd_hi gives 3. A code equal to a boundary goes to the higher level.
- R3: Once locked, comp_mv equals 80 times (lvl_code + 1), which is 80, 160, 240 or 320 for codes 0 to 3. While not_ready is 1, comp_mv is 0.
- R4: Once locked, ovp_ofs equals comp_mv times 5 divided by 4, which is 100, 200, 300 or 400. While not_ready is 1, ovp_ofs is 0.
- R5: A capture window opens only on a rising edge of supply_ok. A valid strobe that arrives with no window open is ignored, and not_ready stays 1.
- R6: The window is tmo_lim clock cycles long, counted from the cycle after the edge is sampled. A valid strobe in any of those cycles, including the last one, is captured.
- R7: If no valid strobe arrives within the window, the block locks level 0 (80 mV) and sets tmo_flag to 1 on the clock edge that ends the last window cycle.
- R8: While locked, new valid strobes and new supply_ok edges leave lvl_code, comp_mv, ovp_ofs and not_ready unchanged.
- R9: tmo_flag stays set until a clear or a reset, and a later supply_ok edge does not reset it.
- R10: A clr pulse returns the block to the R1 output state on the next edge. If supply_ok is still high after the clear, no capture happens until supply_ok falls and rises again.
- R11: A clr that coincides with a valid strobe inside a window wins. The block stays unlocked and the window is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply reached turn-on threshold |
| clr | input | 1 | Synchronous clear (undervoltage or protection shutdown) |
| meas_code | input | CODE_W | Digitized programming-pin current |
| meas_vld | input | 1 | Strobe qualifying meas_code |
| bnd_lo | input | CODE_W | Lowest bin boundary |
| bnd_mid | input | CODE_W | Middle bin boundary |
| bnd_hi | input | CODE_W | Highest bin boundary |
| tmo_lim | input | TMO_W | Capture window length in cycles |
| lvl_code | output | 2 | Locked level code |
| comp_mv | output | MV_W | Compensation value in millivolts |
| ovp_ofs | output | OVP_W | Over-voltage trip offset |
| not_ready | output | 1 | High until a level is locked |
| tmo_flag | output | 1 | Sticky: window closed without a measurement |

## Verification
The classifier is driven with codes on both sides of each boundary, at each boundary exactly, and at the two ends of the code range. These cases separate a correct at-or-above comparison from an off-by-one comparison and from a swapped bin order, and they confirm the millivolt and offset scaling for every level. Directed sequences place a strobe on the last window cycle and let the window run out. Those two cases pin down the window length to the cycle. Further sequences send strobes without an edge, strobes and edges while locked, a clear with supply_ok held high, and a clear in the same cycle as a capture, to show that each of these is ignored or takes priority as required.

// File: rtl/cclvl_pkg.sv
package cclvl_pkg;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int NUM_BND = NUM_LVL - 1;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_LOCK = 2'd2
  } cap_st_e;
endpackage

// File: rtl/cclvl_classify.sv
module cclvl_classify
  import cclvl_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic [CODE_W-1:0]         code,
  input  logic [NUM_BND*CODE_W-1:0] bnds,
  output lvl_t                      lvl
);
  logic [NUM_BND-1:0] hit;

  // one comparator per boundary; a code equal to a boundary counts as reaching it
  for (genvar g = 0; g < NUM_BND; g++) begin : g_cmp
    assign hit[g] = (code >= bnds[g*CODE_W +: CODE_W]);
  end

  always_comb begin
    lvl = '0;
    for (int i = 0; i < NUM_BND; i++) begin
      lvl = lvl + lvl_t'(hit[i]);
    end
  end
endmodule

// File: rtl/cclvl_capture_ctrl.sv
module cclvl_capture_ctrl
  import cclvl_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             clr,
  input  logic             meas_vld,
  input  logic [TMO_W-1:0] tmo_lim,
  input  lvl_t             cls_lvl,
  output lvl_t             lvl_q,
  output logic             locked,
  output logic             tmo_flag
);
  cap_st_e          st_q, st_d;
  logic             sup_q;
  logic             rise;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic [TMO_W:0]   cnt_inc;
  logic             win_end;
  lvl_t             lvl_d;
  logic             flag_q, flag_d;

  assign rise    = supply_ok & ~sup_q;
  assign cnt_inc = {1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1};
  assign win_end = (cnt_inc >= {1'b0, tmo_lim});

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    flag_d = flag_q;
    if (clr) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      lvl_d  = '0;
      flag_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (rise) begin
            st_d  = ST_CAPT;
            cnt_d = '0;
          end
        end
        ST_CAPT: begin
          if (meas_vld) begin
            st_d  = ST_LOCK;
            lvl_d = cls_lvl;
          end else if (win_end) begin
            st_d   = ST_LOCK;
            lvl_d  = '0;
            flag_d = 1'b1;
          end else begin
            cnt_d = cnt_inc[TMO_W-1:0];
          end
        end
        ST_LOCK: st_d = ST_LOCK;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sup_q  <= 1'b0;
      cnt_q  <= '0;
      lvl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sup_q  <= supply_ok;
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      flag_q <= flag_d;
    end
  end

  assign locked   = (st_q == ST_LOCK);
  assign tmo_flag = flag_q;
endmodule

// File: rtl/cclvl_scale.sv
module cclvl_scale
  import cclvl_pkg::*;
#(
  parameter int MV_W      = 10,
  parameter int OVP_W     = 12,
  parameter int STEP_MV   = 80,
  parameter int OVP_NUM   = 5,
  parameter int OVP_SHIFT = 2
) (
  input  lvl_t             lvl,
  input  logic             en,
  output logic [MV_W-1:0]  comp_mv,
  output logic [OVP_W-1:0] ovp_ofs
);
  localparam int PROD_W = 32;

  logic [PROD_W-1:0] mv_full;
  logic [PROD_W-1:0] ovp_full;

  always_comb begin
    mv_full  = '0;
    ovp_full = '0;
    if (en) begin
      mv_full  = (PROD_W'(lvl) + PROD_W'(1)) * PROD_W'(STEP_MV);
      ovp_full = (mv_full * PROD_W'(OVP_NUM)) >> OVP_SHIFT;
    end
  end

  assign comp_mv = mv_full[MV_W-1:0];
  assign ovp_ofs = ovp_full[OVP_W-1:0];
endmodule

// File: rtl/cable_comp_latch.sv
module cable_comp_latch
  import cclvl_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int TMO_W     = 16,
  parameter int MV_W      = 10,
  parameter int OVP_W     = 12,
  parameter int STEP_MV   = 80,
  parameter int OVP_NUM   = 5,
  parameter int OVP_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              clr,
  input  logic [CODE_W-1:0] meas_code,
  input  logic              meas_vld,
  input  logic [CODE_W-1:0] bnd_lo,
  input  logic [CODE_W-1:0] bnd_mid,
  input  logic [CODE_W-1:0] bnd_hi,
  input  logic [TMO_W-1:0]  tmo_lim,
  output logic [1:0]        lvl_code,
  output logic [MV_W-1:0]   comp_mv,
  output logic [OVP_W-1:0]  ovp_ofs,
  output logic              not_ready,
  output logic              tmo_flag
);
  lvl_t cls_lvl;
  lvl_t lvl_q;
  logic locked;

  cclvl_classify #(.CODE_W(CODE_W)) u_cls (
    .code (meas_code),
    .bnds ({bnd_hi, bnd_mid, bnd_lo}),
    .lvl  (cls_lvl)
  );

  cclvl_capture_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .clr       (clr),
    .meas_vld  (meas_vld),
    .tmo_lim   (tmo_lim),
    .cls_lvl   (cls_lvl),
    .lvl_q     (lvl_q),
    .locked    (locked),
    .tmo_flag  (tmo_flag)
  );

  cclvl_scale #(
    .MV_W(MV_W), .OVP_W(OVP_W), .STEP_MV(STEP_MV),
    .OVP_NUM(OVP_NUM), .OVP_SHIFT(OVP_SHIFT)
  ) u_scale (
    .lvl     (lvl_q),
    .en      (locked),
    .comp_mv (comp_mv),
    .ovp_ofs (ovp_ofs)
  );

  assign lvl_code  = lvl_q;
  assign not_ready = ~locked;
endmodule

// File: rtl/cable_comp_latch_chk.sv
module cable_comp_latch_chk #(
  parameter int MV_W  = 10,
  parameter int OVP_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             supply_ok,
  input logic             meas_vld,
  input logic [1:0]       lvl_code,
  input logic [MV_W-1:0]  comp_mv,
  input logic [OVP_W-1:0] ovp_ofs,
  input logic             not_ready,
  input logic             tmo_flag
);
  // R10
  clr_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (not_ready && lvl_code == 2'd0 && !tmo_flag));

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_ready && !clr) |=> ($stable(lvl_code) && $stable(comp_mv) && !not_ready));

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    not_ready |-> (comp_mv == '0 && ovp_ofs == '0));

  // R7
  tmo_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> (!not_ready && lvl_code == 2'd0 && comp_mv == MV_W'(80)));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !clr) |=> tmo_flag);

  // R4
  ovp_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !not_ready |-> (32'(ovp_ofs) * 4 == 32'(comp_mv) * 5));
endmodule

bind cable_comp_latch cable_comp_latch_chk #(.MV_W(MV_W), .OVP_W(OVP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .supply_ok (supply_ok),
  .meas_vld  (meas_vld),
  .lvl_code  (lvl_code),
  .comp_mv   (comp_mv),
  .ovp_ofs   (ovp_ofs),
  .not_ready (not_ready),
  .tmo_flag  (tmo_flag)
);

// File: tb/tb_cable_comp_latch.sv
module tb_cable_comp_latch;
  localparam int CODE_W = 10;
  localparam int TMO_W  = 16;
  localparam int MV_W   = 10;
  localparam int OVP_W  = 12;
  localparam int LIM    = 8;
  localparam int NVEC   = 10;

  // {code, expected level}
  localparam logic [11:0] VEC [NVEC] = '{
    {10'd0,    2'd0}, {10'd99,  2'd0}, {10'd100, 2'd1}, {10'd101, 2'd1},
    {10'd199,  2'd1}, {10'd200, 2'd2}, {10'd299, 2'd2}, {10'd300, 2'd3},
    {10'd301,  2'd3}, {10'd1023, 2'd3}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              supply_ok, clr, meas_vld;
  logic [CODE_W-1:0] meas_code;
  logic [CODE_W-1:0] bnd_lo, bnd_mid, bnd_hi;
  logic [TMO_W-1:0]  tmo_lim;
  logic [1:0]        lvl_code;
  logic [MV_W-1:0]   comp_mv;
  logic [OVP_W-1:0]  ovp_ofs;
  logic              not_ready, tmo_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cable_comp_latch dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .clr(clr),
    .meas_code(meas_code), .meas_vld(meas_vld),
    .bnd_lo(bnd_lo), .bnd_mid(bnd_mid), .bnd_hi(bnd_hi), .tmo_lim(tmo_lim),
    .lvl_code(lvl_code), .comp_mv(comp_mv), .ovp_ofs(ovp_ofs),
    .not_ready(not_ready), .tmo_flag(tmo_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_clr();
    clr = 1'b1;
    step();
    clr = 1'b0;
  endtask

  // drop supply, raise it; returns at negedge right after the edge is sampled
  task automatic open_window();
    supply_ok = 1'b0;
    step();
    supply_ok = 1'b1;
    step();
  endtask

  task automatic give_meas(input logic [CODE_W-1:0] c);
    meas_code = c;
    meas_vld  = 1'b1;
    step();
    meas_vld  = 1'b0;
  endtask

  task automatic chk_locked(input string req, input int lvl);
    chk({req, " not_ready"}, int'(not_ready), 0);
    chk({req, " level"},     int'(lvl_code), lvl);
    chk({req, " comp_mv"},   int'(comp_mv), 80 * (lvl + 1));
    chk({req, " ovp_ofs"},   int'(ovp_ofs), (80 * (lvl + 1) * 5) / 4);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; clr = 1'b0; meas_vld = 1'b0;
    meas_code = '0; bnd_lo = 10'd100; bnd_mid = 10'd200; bnd_hi = 10'd300;
    tmo_lim = TMO_W'(LIM);
    step(); step();
    // R1 reset state
    chk("R1 not_ready", int'(not_ready), 1);
    chk("R1 level", int'(lvl_code), 0);
    chk("R1 comp_mv", int'(comp_mv), 0);
    chk("R1 ovp_ofs", int'(ovp_ofs), 0);
    chk("R1 tmo_flag", int'(tmo_flag), 0);
    rst_n = 1'b1;
    step();

    // R5: strobe with no window open is ignored
    give_meas(10'd500);
    chk("R5 not_ready", int'(not_ready), 1);
    chk("R5 comp_mv", int'(comp_mv), 0);

    // R2 R3 R4: classification table
    for (int i = 0; i < NVEC; i++) begin
      do_clr();
      open_window();
      give_meas(VEC[i][11:2]);
      chk_locked($sformatf("R2 vec%0d", i), int'(VEC[i][1:0]));
    end

    // R8: strobe and new supply edge while locked leave outputs alone
    give_meas(10'd0);
    chk_locked("R8 strobe", 3);
    open_window();
    give_meas(10'd5);
    chk_locked("R8 edge", 3);

    // R10: clear with supply still high, then no capture without a new edge
    do_clr();
    chk("R10 not_ready", int'(not_ready), 1);
    chk("R10 comp_mv", int'(comp_mv), 0);
    give_meas(10'd250);
    chk("R10 no recapture", int'(not_ready), 1);

    // R6: strobe on the last window cycle is captured
    open_window();
    for (int k = 0; k < LIM - 1; k++) step();
    chk("R6 still open", int'(not_ready), 1);
    give_meas(10'd250);
    chk_locked("R6 last cycle", 2);
    chk("R6 no flag", int'(tmo_flag), 0);

    // R7: window runs out
    do_clr();
    open_window();
    for (int k = 0; k < LIM - 1; k++) step();
    chk("R7 before end", int'(not_ready), 1);
    step();
    chk_locked("R7 default", 0);
    chk("R7 flag", int'(tmo_flag), 1);

    // R9: flag survives a new supply edge
    open_window();
    chk("R9 sticky", int'(tmo_flag), 1);
    do_clr();
    chk("R9 cleared", int'(tmo_flag), 0);

    // R11: clear beats a same-cycle capture
    open_window();
    meas_code = 10'd350; meas_vld = 1'b1; clr = 1'b1;
    step();
    meas_vld = 1'b0; clr = 1'b0;
    chk("R11 not_ready", int'(not_ready), 1);
    step();
    chk("R11 window gone", int'(not_ready), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule